// File: doc/BRIEF.md
# Ping-Pong Peripheral-to-Memory DMA Channel

This block is one DMA channel that moves data items from a peripheral into memory. It alternates between two memory buffers and never stops on its own. The peripheral raises a request for each item. The channel writes that item through a simple valid/ready memory write port, then returns a one-cycle acknowledge. When the active buffer has taken the programmed number of items, the channel switches to the other buffer, reloads its item counter and raises a completion flag. While the channel fills one buffer, a downstream agent can empty the other one. The agent can be software or a second engine driven from the flag output.

The completion flag is a level. It stays high until someone writes a one to its bit in a separate write-only clear register. The flag output can therefore serve both as an interrupt and as a hardware trigger that waits to be acknowledged. If a buffer completes while the flag is still set, an overrun bit records the lost notification. Software can also stop the channel in the middle of a buffer. The flag then rises as well, so the consumer can collect the partial data.

Top module: `pp_dma_chan`

## Requirements
- R1: After reset, enable, completion flag, overrun and current-target bit are 0. `per_ack`, `mem_wr_valid` and `tc_out` are low.
- R2: While enable is 0, requests are ignored. No memory write is presented and no acknowledge is given.
- R3: A request that is sampled while idle and enabled starts one item.
  - `mem_wr_valid` rises one cycle later.
  - Address and data stay stable while `mem_wr_ready` is low.
  - `per_ack` is high for exactly the one cycle after the write is accepted.
- R4: The write address is the active base plus (reload count minus remaining count) times 4 bytes. The register map uses word offsets on `reg_addr`:
  - 0: control, with enable in bit 0.
  - 1: base of buffer 0.
  - 2: base of buffer 1.
  - 3: reload count.
  - 4: status (read-only): bit 0 completion flag, bit 1 overrun, bit 2 current target.
  - 5: flag clear (write-only, reads 0).
  - 6: remaining count (read-only).
- R5: On the edge that accepts the last item of a buffer, three things happen together: the current target toggles, the remaining count reloads from the reload count, and the next write goes to the other buffer's base. The idle buffer is never written.
- R6: The channel is circular. After buffer 1 completes, it returns to buffer 0 and keeps running with enable still 1.
- R7: The completion flag is set at the end of every buffer. It is visible on `tc_out` and on status bit 0 from the same edge that accepts the last item, and it stays high until cleared.
- R8: A write to the flag clear register has these effects:
  - Bit 0 clears the completion flag.
  - Bit 1 clears overrun.
  - Bits written as 0, and all other bits, change nothing.
- R9: Clearing enable while the remaining count differs from the reload count sets the completion flag. Clearing enable with a full remaining count does not set it.
- R10: When a buffer completes while the completion flag is already set and not being cleared, overrun is set and the flag stays 1.
- R11: When a completion and a clear of the flag fall on the same edge, the flag ends up 1.
- R12: Writing enable from 0 to 1 restarts the channel at buffer 0 (target 0) with the full reload count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| per_req | input | 1 | Peripheral item request |
| per_data | input | DW (32) | Peripheral item data |
| per_ack | output | 1 | One-cycle acknowledge per item |
| mem_wr_valid | output | 1 | Memory write valid |
| mem_wr_ready | input | 1 | Memory write accepted |
| mem_wr_addr | output | AW (32) | Memory byte address |
| mem_wr_data | output | DW (32) | Memory write data |
| tc_out | output | 1 | Completion flag level, usable as an external trigger |

## Verification
Outputs are due at these times:

| Event | What changes | When |
|-------|--------------|------|
| Request sampled at an edge | `mem_wr_valid` rises | Right after that edge |
| Write accepted at an edge | `per_ack`, the completion flag, the target toggle and the counter reload all appear | Right after that edge |
| After the acknowledge | `per_ack` drops | One cycle later |

Register writes take effect on the edge inside the write strobe.

The bench drives every input on the falling edge and samples on the next falling edge, so each expected value is read half a cycle after the edge that produced it. The same-edge collision of a completion and a clear is built by holding `mem_wr_ready` low, then raising it in the same half-cycle as the clear strobe.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;

    localparam int REG_AW = 3;
    localparam int REG_DW = 32;

    localparam logic [REG_AW-1:0] OFS_CTRL     = 3'd0;
    localparam logic [REG_AW-1:0] OFS_BASE_0   = 3'd1;
    localparam logic [REG_AW-1:0] OFS_BASE_1   = 3'd2;
    localparam logic [REG_AW-1:0] OFS_COUNT    = 3'd3;
    localparam logic [REG_AW-1:0] OFS_STATUS   = 3'd4;
    localparam logic [REG_AW-1:0] OFS_FLAG_CLR = 3'd5;
    localparam logic [REG_AW-1:0] OFS_REMAIN   = 3'd6;

    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,
        XS_WRITE = 2'd1,
        XS_ACK   = 2'd2
    } xfer_state_e;

endpackage

// File: rtl/pp_dma_regs.sv
module pp_dma_regs
    import pp_dma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic              buf_done,
    input  logic              partial,
    input  logic              target,
    input  logic [CNT_W-1:0]  remain,
    output logic              enable,
    output logic              start,
    output logic [AW-1:0]     base_0,
    output logic [AW-1:0]     base_1,
    output logic [CNT_W-1:0]  count,
    output logic              tc_flag
);

    typedef struct packed {
        logic             enable;
        logic [AW-1:0]    base_0;
        logic [AW-1:0]    base_1;
        logic [CNT_W-1:0] count;
        logic             tc;
        logic             ovr;
    } regs_t;

    regs_t q, d;
    logic  stop, clr_tc, clr_ovr, tc_evt;

    always_comb begin
        d       = q;
        start   = 1'b0;
        stop    = 1'b0;
        clr_tc  = reg_wr && (reg_addr == OFS_FLAG_CLR) && reg_wdata[0];
        clr_ovr = reg_wr && (reg_addr == OFS_FLAG_CLR) && reg_wdata[1];
        if (reg_wr) begin
            case (reg_addr)
                OFS_CTRL: begin
                    d.enable = reg_wdata[0];
                    start    = reg_wdata[0] && !q.enable;
                    stop     = !reg_wdata[0] && q.enable;
                end
                OFS_BASE_0: d.base_0 = AW'(reg_wdata);
                OFS_BASE_1: d.base_1 = AW'(reg_wdata);
                OFS_COUNT:  d.count  = CNT_W'(reg_wdata);
                default: ;
            endcase
        end
        tc_evt = buf_done || (stop && partial);
        if (clr_tc)  d.tc  = 1'b0;
        if (clr_ovr) d.ovr = 1'b0;
        if (tc_evt) begin
            d.tc = 1'b1;
            if (q.tc && !clr_tc) d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (reg_addr)
            OFS_CTRL:   reg_rdata = REG_DW'(q.enable);
            OFS_BASE_0: reg_rdata = REG_DW'(q.base_0);
            OFS_BASE_1: reg_rdata = REG_DW'(q.base_1);
            OFS_COUNT:  reg_rdata = REG_DW'(q.count);
            OFS_STATUS: reg_rdata = REG_DW'({target, q.ovr, q.tc});
            OFS_REMAIN: reg_rdata = REG_DW'(remain);
            default:    reg_rdata = '0;
        endcase
    end

    assign enable  = q.enable;
    assign base_0  = q.base_0;
    assign base_1  = q.base_1;
    assign count   = q.count;
    assign tc_flag = q.tc;

    p_tc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.tc && !clr_tc) |=> q.tc);
    p_overrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_done && q.tc && !clr_tc) |=> (q.ovr && q.tc));
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_done && clr_tc) |=> q.tc);
    p_stop_partial_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && partial) |=> q.tc);

endmodule

// File: rtl/pp_dma_xfer.sv
module pp_dma_xfer
    import pp_dma_pkg::*;
#(
    parameter int DW    = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             start,
    input  logic [CNT_W-1:0] count,
    input  logic             per_req,
    input  logic [DW-1:0]    per_data,
    output logic             per_ack,
    output logic             mem_wr_valid,
    input  logic             mem_wr_ready,
    output logic [DW-1:0]    mem_wr_data,
    output logic [CNT_W-1:0] remain,
    output logic             target,
    output logic             buf_done,
    output logic             partial
);

    typedef struct packed {
        xfer_state_e      state;
        logic [CNT_W-1:0] remain;
        logic             target;
        logic [DW-1:0]    data;
        logic             ack;
    } xfer_t;

    xfer_t q, d;

    always_comb begin
        d        = q;
        d.ack    = 1'b0;
        buf_done = 1'b0;
        case (q.state)
            XS_IDLE: begin
                if (enable && per_req) begin
                    d.state = XS_WRITE;
                    d.data  = per_data;
                end
            end
            XS_WRITE: begin
                if (mem_wr_ready) begin
                    d.state = XS_ACK;
                    d.ack   = 1'b1;
                    if (q.remain <= CNT_W'(1)) begin
                        d.remain = count;
                        d.target = !q.target;
                        buf_done = 1'b1;
                    end else begin
                        d.remain = q.remain - CNT_W'(1);
                    end
                end
            end
            XS_ACK:  d.state = XS_IDLE;
            default: d.state = XS_IDLE;
        endcase
        if (start) begin
            d.remain = count;
            d.target = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: XS_IDLE, default: '0};
        else        q <= d;
    end

    assign per_ack      = q.ack;
    assign mem_wr_valid = (q.state == XS_WRITE);
    assign mem_wr_data  = q.data;
    assign remain       = q.remain;
    assign target       = q.target;
    assign partial      = (q.remain != count);

    p_ack_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        per_ack |=> !per_ack);
    p_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && mem_wr_ready && (q.remain <= CNT_W'(1)) && !start)
        |=> ((q.target != $past(q.target)) && (q.remain == $past(count))));

endmodule

// File: rtl/pp_dma_addr.sv
module pp_dma_addr #(
    parameter int AW         = 32,
    parameter int CNT_W      = 16,
    parameter int ITEM_BYTES = 4
) (
    input  logic [AW-1:0]    base_0,
    input  logic [AW-1:0]    base_1,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] remain,
    input  logic             target,
    output logic [AW-1:0]    addr
);

    localparam int  SHIFT  = $clog2(ITEM_BYTES);
    localparam bit  IS_POW = ((ITEM_BYTES & (ITEM_BYTES - 1)) == 0);

    logic [CNT_W-1:0] index;
    logic [AW-1:0]    offset;

    assign index = count - remain;

    generate
        if (IS_POW) begin : g_shift
            assign offset = AW'(index) << SHIFT;
        end else begin : g_mult
            assign offset = AW'(index) * AW'(ITEM_BYTES);
        end
    endgenerate

    assign addr = (target ? base_1 : base_0) + offset;

endmodule

// File: rtl/pp_dma_chan.sv
module pp_dma_chan
    import pp_dma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic              per_req,
    input  logic [DW-1:0]     per_data,
    output logic              per_ack,
    output logic              mem_wr_valid,
    input  logic              mem_wr_ready,
    output logic [AW-1:0]     mem_wr_addr,
    output logic [DW-1:0]     mem_wr_data,
    output logic              tc_out
);

    localparam int ITEM_BYTES = DW / 8;

    logic             enable_w, start_w, buf_done_w, partial_w, target_w;
    logic [AW-1:0]    base_0_w, base_1_w;
    logic [CNT_W-1:0] count_w, remain_w;

    pp_dma_regs #(.AW(AW), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .buf_done  (buf_done_w),
        .partial   (partial_w),
        .target    (target_w),
        .remain    (remain_w),
        .enable    (enable_w),
        .start     (start_w),
        .base_0    (base_0_w),
        .base_1    (base_1_w),
        .count     (count_w),
        .tc_flag   (tc_out)
    );

    pp_dma_xfer #(.DW(DW), .CNT_W(CNT_W)) u_xfer (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable_w),
        .start        (start_w),
        .count        (count_w),
        .per_req      (per_req),
        .per_data     (per_data),
        .per_ack      (per_ack),
        .mem_wr_valid (mem_wr_valid),
        .mem_wr_ready (mem_wr_ready),
        .mem_wr_data  (mem_wr_data),
        .remain       (remain_w),
        .target       (target_w),
        .buf_done     (buf_done_w),
        .partial      (partial_w)
    );

    pp_dma_addr #(.AW(AW), .CNT_W(CNT_W), .ITEM_BYTES(ITEM_BYTES)) u_addr (
        .base_0 (base_0_w),
        .base_1 (base_1_w),
        .count  (count_w),
        .remain (remain_w),
        .target (target_w),
        .addr   (mem_wr_addr)
    );

    p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_valid) |-> $past(enable_w));
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ready)
        |=> (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

endmodule

// File: tb/pp_dma_chan_bench.sv
module pp_dma_chan_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        per_req = 1'b0;
    logic [31:0] per_data = '0;
    logic        per_ack;
    logic        mem_wr_valid;
    logic        mem_wr_ready = 1'b1;
    logic [31:0] mem_wr_addr;
    logic [31:0] mem_wr_data;
    logic        tc_out;

    int checks = 0;
    int fails  = 0;
    int wr_cnt = 0;
    logic [31:0] last_addr = '0;
    logic [31:0] last_data = '0;

    always #5 clk = ~clk;

    pp_dma_chan u_pp_dma_chan (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .per_req(per_req),
        .per_data(per_data), .per_ack(per_ack), .mem_wr_valid(mem_wr_valid),
        .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .tc_out(tc_out)
    );

    always @(posedge clk) begin
        if (rst_n && mem_wr_valid && mem_wr_ready) begin
            wr_cnt    <= wr_cnt + 1;
            last_addr <= mem_wr_addr;
            last_data <= mem_wr_data;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic push(input logic [31:0] data, input logic [31:0] exp_addr,
                        input string req);
        int n0;
        bit seen;
        n0 = wr_cnt;
        seen = 1'b0;
        @(negedge clk);
        per_req = 1'b1; per_data = data;
        for (int i = 0; i < 40 && !seen; i++) begin
            @(negedge clk);
            if (per_ack) seen = 1'b1;
        end
        per_req = 1'b0;
        chk(seen, {req, " ack"}, 32'(seen), 32'd1);
        chk(wr_cnt == n0 + 1, {req, " one write"}, 32'(wr_cnt - n0), 32'd1);
        chk(last_addr == exp_addr, {req, " addr"}, last_addr, exp_addr);
        chk(last_data == data, {req, " data"}, last_data, data);
        @(negedge clk);
        chk(!per_ack, "R3 ack one cycle", 32'(per_ack), 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        reg_read(3'd0, v);
        chk(v == 0, "R1 ctrl reset", v, 0);
        reg_read(3'd4, v);
        chk(v == 0, "R1 status reset", v, 0);
        chk(!per_ack && !mem_wr_valid && !tc_out, "R1 outputs reset",
            {29'd0, per_ack, mem_wr_valid, tc_out}, 0);
    endtask

    task automatic t_disabled_ignored();
        int n0;
        bit any_ack;
        n0 = wr_cnt;
        any_ack = 1'b0;
        reg_write(3'd1, 32'h1000);
        reg_write(3'd2, 32'h2000);
        reg_write(3'd3, 32'd3);
        @(negedge clk);
        per_req = 1'b1; per_data = 32'hDEAD;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (per_ack || mem_wr_valid) any_ack = 1'b1;
        end
        per_req = 1'b0;
        chk(!any_ack, "R2 no activity disabled", 32'(any_ack), 0);
        chk(wr_cnt == n0, "R2 no write disabled", 32'(wr_cnt - n0), 0);
    endtask

    task automatic t_fill_first();
        logic [31:0] v;
        reg_write(3'd0, 32'd1);
        push(32'hA0, 32'h1000, "R4 item0");
        reg_read(3'd6, v);
        chk(v == 2, "R4 remain after one", v, 2);
        push(32'hA1, 32'h1004, "R4 item1");
        reg_read(3'd4, v);
        chk(v == 0, "R7 no flag mid buffer", v, 0);
        push(32'hA2, 32'h1008, "R4 item2");
        reg_read(3'd4, v);
        chk(v == 32'b101, "R5 R7 swap and flag", v, 32'b101);
        reg_read(3'd6, v);
        chk(v == 3, "R5 reload", v, 3);
        chk(tc_out, "R7 tc_out level", 32'(tc_out), 1);
    endtask

    task automatic t_fill_second_overrun();
        logic [31:0] v;
        push(32'hB0, 32'h2000, "R5 other base");
        push(32'hB1, 32'h2004, "R5 item1");
        push(32'hB2, 32'h2008, "R5 item2");
        reg_read(3'd4, v);
        chk(v == 32'b011, "R10 R6 overrun target back", v, 32'b011);
    endtask

    task automatic t_clear_mask();
        logic [31:0] v;
        reg_write(3'd5, 32'hFFFF_FFFC);
        reg_read(3'd4, v);
        chk(v == 32'b011, "R8 zero bits no effect", v, 32'b011);
        reg_write(3'd5, 32'd1);
        reg_read(3'd4, v);
        chk(v == 32'b010, "R8 clear flag only", v, 32'b010);
        chk(!tc_out, "R8 tc_out low", 32'(tc_out), 0);
        reg_write(3'd5, 32'd2);
        reg_read(3'd4, v);
        chk(v == 0, "R8 clear overrun", v, 0);
    endtask

    task automatic t_handshake();
        int n0;
        logic [31:0] a0;
        n0 = wr_cnt;
        @(negedge clk);
        mem_wr_ready = 1'b0; per_req = 1'b1; per_data = 32'hC0;
        @(negedge clk);
        chk(mem_wr_valid, "R3 valid one cycle after req", 32'(mem_wr_valid), 1);
        chk(mem_wr_addr == 32'h1000, "R6 wraps to first buffer", mem_wr_addr, 32'h1000);
        a0 = mem_wr_addr;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(mem_wr_valid && !per_ack && mem_wr_addr == a0, "R3 hold while stalled",
                {30'd0, mem_wr_valid, per_ack}, 32'b10);
        end
        mem_wr_ready = 1'b1;
        @(negedge clk);
        chk(per_ack && !mem_wr_valid, "R3 ack after accept",
            {30'd0, per_ack, mem_wr_valid}, 32'b10);
        per_req = 1'b0;
        @(negedge clk);
        chk(!per_ack, "R3 ack drops", 32'(per_ack), 0);
        chk(wr_cnt == n0 + 1, "R3 single write", 32'(wr_cnt - n0), 1);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        push(32'hC1, 32'h1004, "R4 second item");
        @(negedge clk);
        mem_wr_ready = 1'b0; per_req = 1'b1; per_data = 32'hC2;
        @(negedge clk);
        @(negedge clk);
        mem_wr_ready = 1'b1;
        reg_wr = 1'b1; reg_addr = 3'd5; reg_wdata = 32'd1;
        @(negedge clk);
        reg_wr = 1'b0;
        per_req = 1'b0;
        chk(last_addr == 32'h1008, "R11 last item addr", last_addr, 32'h1008);
        reg_read(3'd4, v);
        chk(v == 32'b101, "R11 set wins over clear", v, 32'b101);
    endtask

    task automatic t_partial_disable();
        logic [31:0] v;
        reg_write(3'd5, 32'd3);
        reg_write(3'd0, 32'd0);
        reg_read(3'd4, v);
        chk(v == 32'b100, "R9 full buffer stop no flag", v, 32'b100);
        reg_write(3'd0, 32'd1);
        reg_read(3'd4, v);
        chk(v == 0, "R12 restart target 0", v, 0);
        push(32'hD0, 32'h1000, "R12 restart addr");
        reg_write(3'd0, 32'd0);
        reg_read(3'd4, v);
        chk(v == 32'b001, "R9 partial stop sets flag", v, 32'b001);
        reg_write(3'd0, 32'd1);
        reg_read(3'd6, v);
        chk(v == 3, "R12 full count on restart", v, 3);
        push(32'hD1, 32'h1000, "R12 restart at base 0");
    endtask

    task automatic t_new_geometry();
        logic [31:0] v;
        reg_write(3'd0, 32'd0);
        reg_write(3'd5, 32'd3);
        reg_write(3'd3, 32'd2);
        reg_write(3'd1, 32'h3000);
        reg_write(3'd0, 32'd1);
        push(32'hE0, 32'h3000, "R4 new base");
        push(32'hE1, 32'h3004, "R4 new count");
        reg_read(3'd4, v);
        chk(v == 32'b101, "R5 swap after two", v, 32'b101);
        push(32'hE2, 32'h2000, "R6 continues other buffer");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_disabled_ignored();
        t_fill_first();
        t_fill_second_overrun();
        t_clear_mask();
        t_handshake();
        t_set_wins();
        t_partial_disable();
        t_new_geometry();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog all requirements actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule